// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flag Word

This block is the arithmetic core of a small execution unit. A combinational datapath takes an opcode, two operands and a width select, and produces a result in either byte mode (low half of the operand) or word mode (full width). The same decode produces six condition flags: carry, parity, auxiliary carry, zero, sign and signed overflow. On a clock edge where the update enable is high, these flags are loaded into a registered status word.

The status word also holds three control bits: single-step trap, interrupt enable and string direction. Only dedicated set and clear opcodes change them, and no arithmetic or logical operation disturbs them. The surrounding sequencer drives one operation per cycle. It takes the result at once and reads the flags from the cycle after the edge that loaded them. Multiply, divide and decimal adjustment are not part of the block.

Top module: `alu_flagcore`

## Requirements
- R1: A synchronous active-high reset clears the whole status word to zero, including the control bits set before it.
- R2: The status word uses these bit positions: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable, 8 direction; bits 15..9 read 0. It changes only on a clock edge where upd_i is high and holds its value otherwise.
- R3: Opcode 0 adds b to a and opcode 1 subtracts b from a, modulo the active width. Carry is the carry out of the active top bit for an add and the borrow (a below b, unsigned) for a subtract.
- R4: Auxiliary carry is set when an add, subtract, increment or decrement carries or borrows from bit 3 into bit 4.
- R5: Parity is set when the low eight bits of the result contain an even number of ones and cleared when the count is odd, in both widths.
- R6: In byte mode (byte_i=1) only the low 8 operand bits take part, result bits 15..8 are 0, and zero and sign are taken from the low 8 result bits. In word mode they are taken from the full 16 bits. Zero is set exactly when the result at the active width is zero, and sign copies its top bit.
- R7: Overflow is set when an add, subtract, increment or decrement gives a two's-complement result outside the signed range of the active width.
- R8: Opcode 3 (increment, a+1) and opcode 4 (decrement, a-1) update every condition flag except carry, which keeps its previous value.
- R9: Opcode 2 (a XOR b) and opcode 5 (bitwise complement of a) clear carry, auxiliary and overflow.
- R10: Opcode 6 shifts a left by one and opcode 7 shifts it right by one, filling with zero. Carry takes the bit shifted out. Auxiliary clears. Overflow is the new top bit XOR carry for a left shift, and the original top bit for a right shift.
- R11: Opcodes 8/9 set/clear trap, 10/11 set/clear interrupt enable, and 12/13 set/clear direction. These commands leave the condition flags unchanged and drive the result to zero. Opcodes 0 to 7 never alter any control bit.
- R12: Opcodes 14 and 15 give a zero result and leave the whole status word unchanged even with upd_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| byte_i | input | 1 | 1 selects byte mode, 0 word mode |
| upd_i | input | 1 | Load the status word at this edge |
| res_o | output | 16 | Combinational result |
| flags_o | output | 16 | Registered status word |

## Verification
The bench builds the block with its defaults: a 16-bit word, an 8-bit byte half and an 8-bit parity window. In byte mode, every value of the first operand is swept against a set of second operands that covers zero, one, the nibble edges and both sign boundaries, for all eight datapath opcodes. This reaches every carry, borrow, half-carry and signed overflow transition of the byte path. Word mode uses pseudo-random operands plus the signed and unsigned extremes. Control commands and idle update cycles are interleaved to show that the two flag groups stay apart.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FLAG_W = 16;

    localparam int FB_CRY = 0;
    localparam int FB_PAR = 1;
    localparam int FB_AUX = 2;
    localparam int FB_ZRO = 3;
    localparam int FB_SGN = 4;
    localparam int FB_OVF = 5;
    localparam int FB_TRP = 6;
    localparam int FB_INT = 7;
    localparam int FB_DIR = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_XOR  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_NOT  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_STRP = 4'd8,
        OP_CTRP = 4'd9,
        OP_SINT = 4'd10,
        OP_CINT = 4'd11,
        OP_SDIR = 4'd12,
        OP_CDIR = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    // packed so that cry lands on bit 0 of the status word
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } cond_t;

    typedef struct packed {
        logic dir;
        logic intr;
        logic trap;
    } ctrl_t;

    localparam int USED_W = $bits(cond_t) + $bits(ctrl_t);

    function automatic logic writes_cond(alu_op_e op);
        return (op <= OP_SHR);
    endfunction

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_XOR) || (op == OP_NOT);
    endfunction

    function automatic logic even_ones(logic [7:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PAR_W   = 8,
    parameter int AUX_BIT = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              byte_i,
    output logic [DATA_W-1:0] res_o,
    output cond_t             cond_o,
    output logic              cond_we_o,
    output logic              keep_cry_o
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] mask, am, opnd, raw, res, axv;
    logic [DATA_W:0]   sum, dif;
    logic              a_msb, o_msb, s_msb, d_msb, r_msb;
    logic              cout_add, bor_sub;

    always_comb begin
        mask = byte_i ? {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}} : {DATA_W{1'b1}};
        am   = a_i & mask;
        if ((op_i == OP_INC) || (op_i == OP_DEC)) begin
            opnd = {{(DATA_W-1){1'b0}}, 1'b1};
        end else begin
            opnd = b_i & mask;
        end
        sum = {1'b0, am} + {1'b0, opnd};
        dif = {1'b0, am} - {1'b0, opnd};
        // upper bits are zero in byte mode, so bit HALF is the carry/borrow
        cout_add = byte_i ? sum[HALF] : sum[DATA_W];
        bor_sub  = byte_i ? dif[HALF] : dif[DATA_W];
        a_msb    = byte_i ? am[HALF-1]   : am[DATA_W-1];
        o_msb    = byte_i ? opnd[HALF-1] : opnd[DATA_W-1];
        s_msb    = byte_i ? sum[HALF-1]  : sum[DATA_W-1];
        d_msb    = byte_i ? dif[HALF-1]  : dif[DATA_W-1];
    end

    always_comb begin
        raw        = '0;
        cond_o     = '0;
        axv        = '0;
        case (op_i)
            OP_ADD, OP_INC: begin
                raw        = sum[DATA_W-1:0];
                cond_o.cry = cout_add;
                axv        = am ^ opnd ^ raw;
                cond_o.aux = axv[AUX_BIT];
                cond_o.ovf = (a_msb == o_msb) && (s_msb != a_msb);
            end
            OP_SUB, OP_DEC: begin
                raw        = dif[DATA_W-1:0];
                cond_o.cry = bor_sub;
                axv        = am ^ opnd ^ raw;
                cond_o.aux = axv[AUX_BIT];
                cond_o.ovf = (a_msb != o_msb) && (d_msb != a_msb);
            end
            OP_XOR: raw = am ^ opnd;
            OP_NOT: raw = ~am;
            OP_SHL: begin
                raw        = am << 1;
                cond_o.cry = a_msb;
                cond_o.ovf = a_msb ^ (byte_i ? am[HALF-2] : am[DATA_W-2]);
            end
            OP_SHR: begin
                raw        = am >> 1;
                cond_o.cry = am[0];
                cond_o.ovf = a_msb;
            end
            default: raw = '0;
        endcase
        res        = raw & mask;
        r_msb      = byte_i ? res[HALF-1] : res[DATA_W-1];
        cond_o.par = even_ones(res[PAR_W-1:0]);
        cond_o.zro = (res == '0);
        cond_o.sgn = r_msb;
    end

    assign res_o      = res;
    assign cond_we_o  = writes_cond(op_i);
    assign keep_cry_o = (op_i == OP_INC) || (op_i == OP_DEC);

endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  alu_op_e           op_i,
    input  cond_t             cond_i,
    input  logic              cond_we_i,
    input  logic              keep_cry_i,
    output logic [FLAG_W-1:0] flags_o
);

    cond_t cond_q, cond_nx;
    ctrl_t ctrl_q, ctrl_nx;

    always_comb begin
        cond_nx = cond_q;
        if (cond_we_i) begin
            cond_nx = cond_i;
            if (keep_cry_i) cond_nx.cry = cond_q.cry;
        end
        ctrl_nx = ctrl_q;
        case (op_i)
            OP_STRP: ctrl_nx.trap = 1'b1;
            OP_CTRP: ctrl_nx.trap = 1'b0;
            OP_SINT: ctrl_nx.intr = 1'b1;
            OP_CINT: ctrl_nx.intr = 1'b0;
            OP_SDIR: ctrl_nx.dir  = 1'b1;
            OP_CDIR: ctrl_nx.dir  = 1'b0;
            default: ctrl_nx = ctrl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            ctrl_q <= '0;
        end else if (upd_i) begin
            cond_q <= cond_nx;
            ctrl_q <= ctrl_nx;
        end
    end

    assign flags_o = {{(FLAG_W-USED_W){1'b0}}, ctrl_q, cond_q};

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o));

    // R8
    inc_dec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i && keep_cry_i |=> $stable(cond_q.cry));

    // R11
    ctrl_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i && cond_we_i |=> $stable(ctrl_q));

    // R9
    logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i && is_logic_op(op_i) |=> !cond_q.cry && !cond_q.aux && !cond_q.ovf);

endmodule

// File: rtl/alu_flagcore.sv
module alu_flagcore
    import alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              byte_i,
    input  logic              upd_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o
);

    alu_op_e op;
    cond_t   cond;
    logic    cond_we, keep_cry;

    assign op = alu_op_e'(op_i);

    alu_arith #(.DATA_W(DATA_W), .PAR_W(PAR_W), .AUX_BIT(4)) u_arith (
        .op_i      (op),
        .a_i       (a_i),
        .b_i       (b_i),
        .byte_i    (byte_i),
        .res_o     (res_o),
        .cond_o    (cond),
        .cond_we_o (cond_we),
        .keep_cry_o(keep_cry)
    );

    alu_flagreg u_flags (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (upd_i),
        .op_i      (op),
        .cond_i    (cond),
        .cond_we_i (cond_we),
        .keep_cry_i(keep_cry),
        .flags_o   (flags_o)
    );

    // R5
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i && (op_i < 4'd8) |=> flags_o[FB_PAR] == ~^$past(res_o[PAR_W-1:0]));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i && (op_i < 4'd8) |=> flags_o[FB_ZRO] == ($past(res_o) == '0));

    // R12
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        op_i >= 4'd14 |=> $stable(flags_o));

endmodule

// File: tb/test_alu_flagcore.sv
`timescale 1ns/1ps
module test_alu_flagcore;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'd0;
    logic [15:0] a = '0, b = '0;
    logic        byt = 1'b0, upd = 1'b0;
    logic [15:0] res, flags;

    int n_run = 0, n_fail = 0, cycles = 0;
    logic [15:0] exp_fl = '0;
    int last_op = 0;

    always #2 clk = ~clk;

    alu_flagcore i_alu_flagcore (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
        .byte_i(byt), .upd_i(upd), .res_o(res), .flags_o(flags)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h byte=%0d got=%h exp=%h", what, op, a, b, byt, got, exp);
        end
    endtask

    function automatic int sx(int x, int w);
        return (x >= (1 << (w-1))) ? x - (1 << w) : x;
    endfunction

    // returns {flags_next, result}
    function automatic logic [31:0] model(int o, int ai, int bi, bit by, logic [15:0] fl, bit u);
        int w = by ? 8 : 16;
        int m = (1 << w) - 1;
        int aa = ai & m, bb = bi & m, ob, r = 0, s;
        bit c = fl[0], ax = 1'b0, ov = 1'b0, cond = 1'b0;
        logic [15:0] nf = fl;
        case (o)
            0, 3: begin
                ob = (o == 3) ? 1 : bb; r = (aa + ob) & m;
                if (o == 0) c = (aa + ob) > m;
                ax = ((aa & 15) + (ob & 15)) > 15;
                s = sx(aa, w) + sx(ob, w);
                ov = (s >= (1 << (w-1))) || (s < -(1 << (w-1))); cond = 1;
            end
            1, 4: begin
                ob = (o == 4) ? 1 : bb; r = (aa - ob) & m;
                if (o == 1) c = aa < ob;
                ax = (aa & 15) < (ob & 15);
                s = sx(aa, w) - sx(ob, w);
                ov = (s >= (1 << (w-1))) || (s < -(1 << (w-1))); cond = 1;
            end
            2: begin r = aa ^ bb; c = 0; cond = 1; end
            5: begin r = (~aa) & m; c = 0; cond = 1; end
            6: begin r = (aa << 1) & m; c = (aa >> (w-1)) & 1; ov = ((r >> (w-1)) & 1) ^ c; cond = 1; end
            7: begin r = aa >> 1; c = aa & 1; ov = (aa >> (w-1)) & 1; cond = 1; end
            8, 9, 10, 11, 12, 13: if (u) nf[6 + (o-8)/2] = (o % 2 == 0);
            default: r = 0;
        endcase
        if (cond && u) begin
            nf[0] = c;
            nf[1] = ~^(r[7:0]);
            nf[2] = ax;
            nf[3] = (r == 0);
            nf[4] = (r >> (w-1)) & 1;
            nf[5] = ov;
        end
        return {nf, r[15:0]};
    endfunction

    function automatic string req_of(int o);
        case (o)
            0, 1: return "R3";
            3, 4: return "R8";
            2, 5: return "R9";
            6, 7: return "R10";
            14, 15: return "R12";
            default: return "R11";
        endcase
    endfunction

    task automatic check_flags();
        string rq = req_of(last_op);
        chk({15'd0, flags[0]}, {15'd0, exp_fl[0]}, {rq, " carry"});
        chk({15'd0, flags[1]}, {15'd0, exp_fl[1]}, "R5 parity");
        chk({15'd0, flags[2]}, {15'd0, exp_fl[2]}, "R4 aux");
        chk({15'd0, flags[3]}, {15'd0, exp_fl[3]}, "R6 zero");
        chk({15'd0, flags[4]}, {15'd0, exp_fl[4]}, "R6 sign");
        chk({15'd0, flags[5]}, {15'd0, exp_fl[5]}, "R7 overflow");
        chk({13'd0, flags[8:6]}, {13'd0, exp_fl[8:6]}, "R11 control bits");
        chk({flags[15:9], 9'd0}, 16'd0, "R2 unused bits");
    endtask

    task automatic step(input int o, input int ai, input int bi, input bit by, input bit u);
        logic [31:0] mv;
        @(negedge clk);
        check_flags();
        op = o[3:0]; a = ai[15:0]; b = bi[15:0]; byt = by; upd = u;
        #1;
        mv = model(o, ai, bi, by, exp_fl, u);
        chk(res, mv[15:0], (by && res[15:8] != 0) ? "R6 byte result" : {req_of(o), " result"});
        exp_fl = mv[31:16];
        last_op = u ? o : 99;
        if (!u) last_op = 99;
    endtask

    function automatic int bpick(int k);
        case (k)
            16: return 8'h80;
            17: return 8'h7F;
            18: return 8'h0F;
            19: return 8'h01;
            default: return k * 17;
        endcase
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        logic [15:0] lf = 16'hACE1;
        int vn = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: status word zero out of reset
        @(negedge clk);
        chk(flags, 16'h0000, "R1 reset state");
        exp_fl = '0;

        // byte-mode sweep over every first operand
        for (int o = 0; o < 8; o++)
            for (int ai = 0; ai < 256; ai++)
                for (int k = 0; k < 20; k++) begin
                    vn++;
                    step(o, ai | 16'hA500, bpick(k) | 16'h5A00, 1'b1, (vn % 7) != 0); // R2 idle cycles
                end

        // word-mode edge values
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    int ev[6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h000F};
                    step(o, ev[i], ev[j], 1'b0, 1'b1);
                end

        // word-mode pseudo-random operands
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 1500; i++) begin
                int x, y;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                x = lf;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                y = lf;
                step(o, x, y, 1'b0, (i % 11) != 5);
            end

        // R11 / R12: control commands interleaved with arithmetic
        for (int i = 0; i < 400; i++) begin
            int x;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            x = lf;
            step(8 + (x % 8), x, x, 1'b0, x[3]);
            step(x % 8, x ^ 16'h3C3C, x, x[5], 1'b1);
        end

        // R1: reset clears control bits previously set
        step(8, 0, 0, 1'b0, 1'b1);
        step(10, 0, 0, 1'b0, 1'b1);
        step(12, 0, 0, 1'b0, 1'b1);
        step(0, 16'hFFFF, 1, 1'b0, 1'b1);
        @(negedge clk);
        check_flags();
        upd = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(flags, 16'h0000, "R1 reset clears all");
        exp_fl = '0;
        last_op = 99;
        step(14, 0, 0, 1'b0, 1'b1);
        @(negedge clk);
        check_flags();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule